// File: doc/BRIEF.md
# 4x4 Inverse Walsh-Hadamard Transform

This block reconstructs the DC terms of the sixteen luma 4x4 subblocks of a macroblock from its second-order block. It accepts sixteen signed 16-bit coefficients in a single load, guarded by a valid/ready handshake. It runs two add/subtract-only butterfly passes over the block. The first pass works down the columns and the second across the rows. Each result is rounded by adding 3 and shifting right arithmetically by 3.

The sixteen rounded results then leave one per clock as (subblock index, value) writes, in subblock raster order 0 to 15. Each write targets the DC slot of the subblock it names. One cycle after the last write a single-cycle done pulse is raised, and the block then takes the next load. The inverse quantisation that comes before this block and the per-subblock inverse DCT that comes after it are left to neighbouring blocks.

Top module: `iwht4x4`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `out_valid` and `out_done` are 0.
- R2: Coefficient k of `in_coef` sits at bits [16k+15:16k] and has row k/4 and column k%4. The first pass works on each column with rows r0..r3: a=r0+r3, b=r1+r2, c=r1-r2, d=r0-r3. It gives row 0 = a+b, row 1 = c+d, row 2 = a-b and row 3 = d-c.
- R3: The second pass applies the same butterfly along each row of the first-pass result, with columns in place of rows. Its output (row i, column j) goes to subblock 4i+j, so d-c lands in column 3.
- R4: Each output is (x+3)>>3 with an arithmetic shift, so negative values round toward minus infinity after the +3 bias.
- R5: The writes come on 16 consecutive cycles with `out_valid` high and `out_idx` counting 0,1,...,15.
- R6: `out_done` is high for exactly one cycle, the cycle right after the write with index 15, and `out_valid` is 0 in that cycle.
- R7: `in_ready` is 0 from the cycle after a load is accepted up to and including the done cycle. An `in_valid` during that time is ignored and does not change any output value.
- R8: The first write (index 0) appears on the second clock edge after the edge that accepts the load. At the first edge after acceptance `out_valid` is still 0.
- R9: Outputs are 17-bit signed and exact over the full input range: a block of all -32768 gives -65536 in slot 0 and 0 in every other slot. A block of all 32767 gives 65534 in slot 0 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Load request for `in_coef` |
| in_ready | output | 1 | Block is idle and takes a load |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, row-major |
| out_valid | output | 1 | A result write is presented |
| out_idx | output | 4 | Target subblock index of the write |
| out_val | output | 17 | Signed rounded DC value for that subblock |
| out_done | output | 1 | One-cycle pulse after the last write |

## Verification
A fault in the first-pass register or in the butterfly wiring corrupts several values of the same block. The wrong values show on the write bus two to seventeen cycles after the load. Single impulses at every input position, with several magnitudes, give each such fault a distinct pattern across the sixteen slots. A sequencing fault shows at once as a skipped or repeated index, a missing or early done pulse, or `in_ready` rising while writes are still pending. Loads offered while the block is busy check that the stored block is not overwritten.

// File: rtl/iwht_pkg.sv
// Shared definitions for the inverse Walsh-Hadamard block.
// Assumes a fixed 4x4 block; only the coefficient width is configurable.
package iwht_pkg;
    localparam int DIM = 4;
    localparam int NCOEF = DIM * DIM;
    localparam int IDX_W = $clog2(NCOEF);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COLS = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } iwht_state_t;
endpackage

// File: rtl/iwht_bfly4.sv
// Four-point add/subtract butterfly used by both transform passes.
// Output order: sum of sums, c+d, difference of sums, d-c.
// Assumes signed inputs; outputs grow by two bits so nothing overflows.
module iwht_bfly4 #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   x0,
    input  logic signed [W-1:0]   x1,
    input  logic signed [W-1:0]   x2,
    input  logic signed [W-1:0]   x3,
    output logic signed [W+1:0]   y0,
    output logic signed [W+1:0]   y1,
    output logic signed [W+1:0]   y2,
    output logic signed [W+1:0]   y3
);
    logic signed [W:0] s_outer, s_inner, d_inner, d_outer;

    // Outer/inner pair sums and differences, then the output combination.
    always_comb begin
        s_outer = (W+1)'(x0) + (W+1)'(x3);
        s_inner = (W+1)'(x1) + (W+1)'(x2);
        d_inner = (W+1)'(x1) - (W+1)'(x2);
        d_outer = (W+1)'(x0) - (W+1)'(x3);
        y0 = (W+2)'(s_outer) + (W+2)'(s_inner);
        y1 = (W+2)'(d_inner) + (W+2)'(d_outer);
        y2 = (W+2)'(s_outer) - (W+2)'(s_inner);
        y3 = (W+2)'(d_outer) - (W+2)'(d_inner);
    end
endmodule

// File: rtl/iwht_round.sv
// Final rounding: add 3, then arithmetic shift right by 3.
// Assumes the input has headroom for the +3 bias (true for full-range data).
module iwht_round #(
    parameter int W = 20
) (
    input  logic signed [W-1:0]   x,
    output logic signed [W-4:0]   y
);
    logic signed [W-1:0] biased;

    // Bias then drop the three fraction bits, keeping the sign.
    always_comb begin
        biased = x + W'(3);
        y = biased[W-1:3];
    end
endmodule

// File: rtl/iwht4x4.sv
// Inverse 4x4 Walsh-Hadamard transform with serial DC-slot writes.
// Load: one handshake takes 16 row-major coefficients. The column pass is
// registered at acceptance, the row pass plus rounding one cycle later, and
// then 16 writes leave in subblock order followed by a one-cycle done pulse.
// Assumes the consumer always takes a write (no back-pressure on the output).
module iwht4x4
    import iwht_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [iwht_pkg::NCOEF*IN_W-1:0]      in_coef,
    output logic                                 out_valid,
    output logic [iwht_pkg::IDX_W-1:0]           out_idx,
    output logic signed [IN_W:0]                 out_val,
    output logic                                 out_done
);
    localparam int P1_W  = IN_W + 2;
    localparam int P2_W  = IN_W + 4;
    localparam int OUT_W = P2_W - 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCOEF - 1);

    iwht_state_t state_q;
    logic [IDX_W-1:0] idx_q;
    logic signed [IN_W-1:0]  coef_w [NCOEF];
    logic signed [P1_W-1:0]  p1_d   [NCOEF];
    logic signed [P1_W-1:0]  p1_q   [NCOEF];
    logic signed [P2_W-1:0]  p2_d   [NCOEF];
    logic signed [OUT_W-1:0] res_d  [NCOEF];
    logic signed [OUT_W-1:0] res_q  [NCOEF];
    logic accept;

    assign accept = in_valid && (state_q == ST_IDLE);

    genvar k;
    generate
        for (k = 0; k < NCOEF; k++) begin : g_unpack
            assign coef_w[k] = in_coef[k*IN_W +: IN_W];
        end

        // Column pass: rows 0/3 and 1/2 paired within each column.
        for (k = 0; k < DIM; k++) begin : g_col
            iwht_bfly4 #(.W(IN_W)) u_col (
                .x0(coef_w[k]),       .x1(coef_w[DIM+k]),
                .x2(coef_w[2*DIM+k]), .x3(coef_w[3*DIM+k]),
                .y0(p1_d[k]),         .y1(p1_d[DIM+k]),
                .y2(p1_d[2*DIM+k]),   .y3(p1_d[3*DIM+k])
            );
        end

        // Row pass on the registered column results.
        for (k = 0; k < DIM; k++) begin : g_row
            iwht_bfly4 #(.W(P1_W)) u_row (
                .x0(p1_q[k*DIM]),   .x1(p1_q[k*DIM+1]),
                .x2(p1_q[k*DIM+2]), .x3(p1_q[k*DIM+3]),
                .y0(p2_d[k*DIM]),   .y1(p2_d[k*DIM+1]),
                .y2(p2_d[k*DIM+2]), .y3(p2_d[k*DIM+3])
            );
        end

        for (k = 0; k < NCOEF; k++) begin : g_rnd
            iwht_round #(.W(P2_W)) u_rnd (.x(p2_d[k]), .y(res_d[k]));
        end
    endgenerate

    // Control sequence: idle -> row pass -> 16 writes -> done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_COLS;
                ST_COLS: begin
                    state_q <= ST_EMIT;
                    idx_q   <= '0;
                end
                ST_EMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Column-pass storage, loaded only on an accepted handshake.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < NCOEF; i++) p1_q[i] <= p1_d[i];
        end
    end

    // Rounded result storage, loaded after the row pass.
    always_ff @(posedge clk) begin
        if (state_q == ST_COLS) begin
            for (int i = 0; i < NCOEF; i++) res_q[i] <= res_d[i];
        end
    end

    // Port outputs, all taken straight from registered state.
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_done  = (state_q == ST_DONE);
        out_idx   = idx_q;
        out_val   = res_q[idx_q];
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_done) |-> !in_ready); // R7
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1)); // R5
    AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == '0)); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ($past(out_valid) && $past(out_idx) == LAST_IDX && !out_valid)); // R6
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R8
endmodule

// File: tb/sim_iwht4x4.sv
module sim_iwht4x4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [255:0] in_coef = '0;
    logic out_valid;
    logic [3:0] out_idx;
    logic signed [16:0] out_val;
    logic out_done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    iwht4x4 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .out_valid(out_valid), .out_idx(out_idx),
        .out_val(out_val), .out_done(out_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Arithmetic model from the requirements: column pass, row pass, rounding.
    task automatic ref_model(input logic [255:0] blk, output int e[16]);
        int x[16];
        int p[16];
        int a, b, c, d;
        for (int k = 0; k < 16; k++) x[k] = int'($signed(blk[k*16 +: 16]));
        for (int col = 0; col < 4; col++) begin
            a = x[col] + x[12+col]; b = x[4+col] + x[8+col];
            c = x[4+col] - x[8+col]; d = x[col] - x[12+col];
            p[col] = a + b; p[4+col] = c + d; p[8+col] = a - b; p[12+col] = d - c;
        end
        for (int r = 0; r < 4; r++) begin
            a = p[r*4] + p[r*4+3]; b = p[r*4+1] + p[r*4+2];
            c = p[r*4+1] - p[r*4+2]; d = p[r*4] - p[r*4+3];
            e[r*4]   = (a + b + 3) >>> 3;
            e[r*4+1] = (c + d + 3) >>> 3;
            e[r*4+2] = (a - b + 3) >>> 3;
            e[r*4+3] = (d - c + 3) >>> 3;
        end
    endtask

    task automatic run_block(input logic [255:0] blk, input bit poke, input string tag);
        int e[16];
        ref_model(blk, e);
        @(negedge clk);
        chk("R7 ready before load", int'(in_ready), 1);
        in_valid = 1'b1;
        in_coef = blk;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 ready after accept", int'(in_ready), 0);
        if (poke) begin
            in_valid = 1'b1;
            in_coef = ~blk;
        end
        chk("R8 no write one edge after accept", int'(out_valid), 0);
        @(negedge clk);
        for (int j = 0; j < 16; j++) begin
            chk("R5 write valid", int'(out_valid), 1);
            chk("R5 write index", int'(out_idx), j);
            chk(tag, int'(out_val), e[j]);
            chk("R7 busy not ready", int'(in_ready), 0);
            @(negedge clk);
        end
        chk("R6 done pulse", int'(out_done), 1);
        chk("R6 no write in done cycle", int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R6 done single cycle", int'(out_done), 0);
    endtask

    function automatic logic [255:0] impulse(input int pos, input int v);
        logic [255:0] b = '0;
        b[pos*16 +: 16] = 16'(v);
        return b;
    endfunction

    initial begin : main
        int vals[6] = '{1, -1, 8, -9, 32767, -32768};
        logic [255:0] blk;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", int'(in_ready), 1);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset done", int'(out_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(in_ready), 1);
        chk("R1 idle after reset", int'(out_valid) + int'(out_done), 0);

        run_block('0, 1'b0, "R2 R3 zero block value");
        for (int p = 0; p < 16; p++)
            for (int v = 0; v < 6; v++)
                run_block(impulse(p, vals[v]), 1'b0, "R2 R3 impulse value");
        for (int v = -20; v <= 20; v++)
            run_block(impulse(0, v), 1'b0, "R4 rounding value");
        for (int k = 0; k < 16; k++) blk[k*16 +: 16] = 16'h8000;
        run_block(blk, 1'b0, "R9 all minimum value");
        for (int k = 0; k < 16; k++) blk[k*16 +: 16] = 16'h7fff;
        run_block(blk, 1'b0, "R9 all maximum value");
        for (int k = 0; k < 16; k++) blk[k*16 +: 16] = k[0] ? 16'h8000 : 16'h7fff;
        run_block(blk, 1'b0, "R9 alternating extremes value");
        for (int n = 0; n < 50; n++) begin
            for (int k = 0; k < 16; k++) begin
                rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
                blk[k*16 +: 16] = rng[15:0];
            end
            run_block(blk, n[0], "R2 R3 R4 R7 random value");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule